// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block turns a reference clock into the two clocks an audio serial port needs: a fast master clock for converters and a slower bit clock that paces serial data. It has two independent lanes, one for transmit and one for receive. Each lane picks a system reference or an oscillator reference and divides it by a fixed two, then by an optional prescale of eight, then by a programmable factor of 1 to 256. A final fine divider of 1 to 16 produces the bit clock from the master clock.

The block runs on a single fast core clock. The two references and the external master clock are level signals, sampled in that domain, and each lane detects their edges. A passthrough mode sends the oscillator straight to the master clock output and leaves only the fine divider in the path to the bit clock. A direction bit per lane decides whether the lane drives its master-clock pin or takes an external master clock from that pin. Polarity bits invert each output clock separately. Divider fields can be rewritten at any time. A new value is loaded only when a stage reaches the end of its count, so no short pulse appears.

Top module: `audio_clk_div`

## Requirements
- R1: While reset is high, and on the first edge after it rises, every master clock output, bit clock output and pin enable is 0. All counters restart.
- R2: When the lane drives its pin and passthrough is inactive, the master clock is high for P×M reference periods and low for P×M reference periods. P is 8 when the lane's prescale bit is 1 and 1 when it is 0. M is the 8-bit divide field plus one, so field 0 gives 1 and field 255 gives 256.
- R3: Source select 0 takes the system reference and source select 1 takes the oscillator reference. Edges are counted on the rising edge of the selected reference.
- R4: The bit clock is high for F master half-periods and low for F master half-periods. F is the 4-bit fine field plus one, giving 1 to 16. In normal mode each bit-clock transition happens on the same cycle as a master-clock transition.
- R5: With passthrough set, source select 1 and the pin driven, the master clock output equals the oscillator level two core cycles earlier, XOR the master polarity bit. The bit clock then toggles every F oscillator edges.
- R6: The passthrough bit has no effect while source select is 0. The lane divides normally as in R2.
- R7: The pin enable follows the direction bit one cycle later, with 1 meaning the lane drives its pin. When the direction bit is 0, the master clock output stays 0 and the bit clock toggles every F edges of the external master clock input.
- R8: Each output is the internal clock XOR its own polarity bit. On the first edge after reset, a driven master output equals its polarity bit and the bit clock output equals its polarity bit.
- R9: A new divide value written in mid-period takes effect only at the end of that stage's count. Every master half-period is therefore either the whole old length or the whole new length.
- R10: The two lanes are independent. Each lane's outputs depend only on its own controls and the shared references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples references and runs all counters |
| rst | input | 1 | Synchronous active-high reset |
| ref_sys_i | input | 1 | System reference clock level |
| ref_osc_i | input | 1 | Oscillator reference clock level |
| mclk_in_i | input | NL | External master clock level per lane, used when the pin is an input |
| src_sel_i | input | NL | Reference select per lane: 0 system, 1 oscillator |
| pre8_i | input | NL | Prescale select per lane: 1 divides by 8, 0 bypasses |
| mdiv_i | input | NL*MW | Divide field per lane, value plus one is M |
| fdiv_i | input | NL*FW | Fine field per lane, value plus one is F |
| pass_i | input | NL | Passthrough request per lane |
| mdir_out_i | input | NL | Pin direction per lane: 1 drive, 0 receive |
| inv_m_i | input | NL | Master clock polarity per lane |
| inv_b_i | input | NL | Bit clock polarity per lane |
| mclk_o | output | NL | Master clock per lane |
| mclk_oe_o | output | NL | Master clock pin enable per lane |
| bclk_o | output | NL | Bit clock per lane |

## Verification
A prescale or divide counter that holds a wrong value shows up at the ports as a master half-period of the wrong length, within one period of the slowest stage. A broken fine counter shows up as a wrong bit-clock width, or as a bit-clock edge with no master-clock edge in the same cycle, after at most sixteen master half-periods. Wrong mode decoding shows up within two core cycles: the pin enable no longer matches the direction bit, a receiving lane drives a nonzero master output, or the passthrough output stops tracking the oscillator. A reload that happens at the wrong time shows up as a master half-period that is neither the old length nor the new one.

// File: rtl/acd_pkg.sv
package acd_pkg;

  typedef enum logic {
    SRC_SYS = 1'b0,
    SRC_OSC = 1'b1
  } src_e;

  // Reload value of the prescale stage for a given prescale selection.
  function automatic int unsigned pre_reload(logic pre8, int unsigned pre_div);
    return pre8 ? (pre_div - 1) : 0;
  endfunction

  // Rising transition between two samples of a level.
  function automatic logic rise_of(logic now_v, logic was_v);
    return now_v & ~was_v;
  endfunction

  // Any transition between two samples of a level.
  function automatic logic flip_of(logic now_v, logic was_v);
    return now_v ^ was_v;
  endfunction

endpackage

// File: rtl/acd_count_stage.sv
// One down-counting divide stage. It emits a terminal pulse on every
// reload-plus-one input events. The reload value is sampled only at
// terminal count, so a new value never shortens a period in progress.
module acd_count_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev_i,
  input  logic [W-1:0] reload_i,
  output logic         tc_o
);

  logic [W-1:0] cnt;
  logic         at_zero;

  assign at_zero = (cnt == '0);
  assign tc_o    = ev_i & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ev_i) begin
      if (at_zero) cnt <= reload_i;
      else         cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/acd_lane.sv
// One direction of the clock chain: reference select, prescale, main
// divide, optional oscillator passthrough, pin direction, fine divide
// and output polarity.
module acd_lane
  import acd_pkg::*;
#(
  parameter int MW      = 8,
  parameter int FW      = 4,
  parameter int PRE_DIV = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_sys_i,
  input  logic          ref_osc_i,
  input  logic          mclk_in_i,
  input  logic          src_sel_i,
  input  logic          pre8_i,
  input  logic [MW-1:0] mdiv_i,
  input  logic [FW-1:0] fdiv_i,
  input  logic          pass_i,
  input  logic          mdir_out_i,
  input  logic          inv_m_i,
  input  logic          inv_b_i,
  output logic          mclk_o,
  output logic          mclk_oe_o,
  output logic          bclk_o,
  output logic          pt_act_o,
  output logic          mtog_o,
  output logic          btog_o
);

  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  // Previous samples of the incoming levels
  logic sys_q, osc_q, ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q <= 1'b0;
      osc_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      sys_q <= ref_sys_i;
      osc_q <= ref_osc_i;
      ext_q <= mclk_in_i;
    end
  end

  // Mode decode
  logic src_osc, pt_act, run_div;

  assign src_osc = (src_e'(src_sel_i) == SRC_OSC);
  assign pt_act  = pass_i & src_osc & mdir_out_i;
  assign run_div = mdir_out_i & ~pt_act;

  // Reference edge events
  logic ref_rise;

  assign ref_rise = src_osc ? rise_of(ref_osc_i, osc_q)
                            : rise_of(ref_sys_i, sys_q);

  // Prescale and main divide stages
  logic [PW-1:0] pre_rl;
  logic          tc_pre, tc_m;

  assign pre_rl = PW'(pre_reload(pre8_i, PRE_DIV));

  acd_count_stage #(.W(PW)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (ref_rise & run_div),
    .reload_i (pre_rl),
    .tc_o     (tc_pre)
  );

  acd_count_stage #(.W(MW)) u_main (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (tc_pre),
    .reload_i (mdiv_i),
    .tc_o     (tc_m)
  );

  // Half-period events feeding the fine divider
  logic half_ev, tc_f;

  always_comb begin
    if (!mdir_out_i)  half_ev = flip_of(mclk_in_i, ext_q);
    else if (pt_act)  half_ev = flip_of(ref_osc_i, osc_q);
    else              half_ev = tc_m;
  end

  acd_count_stage #(.W(FW)) u_fine (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (half_ev),
    .reload_i (fdiv_i),
    .tc_o     (tc_f)
  );

  // Internal clock levels
  logic mclk_div, bclk_int, mclk_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_div <= 1'b0;
      bclk_int <= 1'b0;
    end else begin
      if (tc_m) mclk_div <= ~mclk_div;
      if (tc_f) bclk_int <= ~bclk_int;
    end
  end

  assign mclk_sel = pt_act ? osc_q : mclk_div;

  // Registered outputs with polarity; held low in reset
  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_o    <= 1'b0;
      mclk_oe_o <= 1'b0;
      bclk_o    <= 1'b0;
    end else begin
      mclk_o    <= mdir_out_i ? (mclk_sel ^ inv_m_i) : 1'b0;
      mclk_oe_o <= mdir_out_i;
      bclk_o    <= bclk_int ^ inv_b_i;
    end
  end

  assign pt_act_o = pt_act;
  assign mtog_o   = tc_m;
  assign btog_o   = tc_f;

endmodule

// File: rtl/audio_clk_div.sv
// Two-lane audio clock divider: lane 0 transmit, lane 1 receive.
module audio_clk_div #(
  parameter int NL      = 2,
  parameter int MW      = 8,
  parameter int FW      = 4,
  parameter int PRE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_sys_i,
  input  logic             ref_osc_i,
  input  logic [NL-1:0]    mclk_in_i,
  input  logic [NL-1:0]    src_sel_i,
  input  logic [NL-1:0]    pre8_i,
  input  logic [NL*MW-1:0] mdiv_i,
  input  logic [NL*FW-1:0] fdiv_i,
  input  logic [NL-1:0]    pass_i,
  input  logic [NL-1:0]    mdir_out_i,
  input  logic [NL-1:0]    inv_m_i,
  input  logic [NL-1:0]    inv_b_i,
  output logic [NL-1:0]    mclk_o,
  output logic [NL-1:0]    mclk_oe_o,
  output logic [NL-1:0]    bclk_o
);

  // Internal events brought out for the checker
  logic [NL-1:0] lane_pt_act;
  logic [NL-1:0] lane_mtog;
  logic [NL-1:0] lane_btog;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    acd_lane #(
      .MW      (MW),
      .FW      (FW),
      .PRE_DIV (PRE_DIV)
    ) u_lane (
      .clk        (clk),
      .rst        (rst),
      .ref_sys_i  (ref_sys_i),
      .ref_osc_i  (ref_osc_i),
      .mclk_in_i  (mclk_in_i[g]),
      .src_sel_i  (src_sel_i[g]),
      .pre8_i     (pre8_i[g]),
      .mdiv_i     (mdiv_i[g*MW +: MW]),
      .fdiv_i     (fdiv_i[g*FW +: FW]),
      .pass_i     (pass_i[g]),
      .mdir_out_i (mdir_out_i[g]),
      .inv_m_i    (inv_m_i[g]),
      .inv_b_i    (inv_b_i[g]),
      .mclk_o     (mclk_o[g]),
      .mclk_oe_o  (mclk_oe_o[g]),
      .bclk_o     (bclk_o[g]),
      .pt_act_o   (lane_pt_act[g]),
      .mtog_o     (lane_mtog[g]),
      .btog_o     (lane_btog[g])
    );
  end

endmodule

// File: rtl/audio_clk_div_chk.sv
module audio_clk_div_chk #(
  parameter int NL = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ref_osc_i,
  input logic [NL-1:0] mdir_out_i,
  input logic [NL-1:0] inv_m_i,
  input logic [NL-1:0] inv_b_i,
  input logic [NL-1:0] mclk_o,
  input logic [NL-1:0] mclk_oe_o,
  input logic [NL-1:0] bclk_o,
  input logic [NL-1:0] lane_pt_act,
  input logic [NL-1:0] lane_mtog,
  input logic [NL-1:0] lane_btog
);

  logic       rst_q;
  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  assign warm = (since_rst == 2'd3);

  // R1: outputs cleared on the edge that samples reset
  always @(negedge clk) begin
    if (rst_q) begin
      a_rst_low_r1: assert (mclk_o == '0 && bclk_o == '0 && mclk_oe_o == '0)
        else $error("outputs not low after reset edge");
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_chk
    logic norm;
    assign norm = mdir_out_i[i] & ~lane_pt_act[i];

    // R7: pin enable follows direction one cycle later
    p_oe_dir_r7: assert property (@(posedge clk) disable iff (rst)
      warm |-> (mclk_oe_o[i] == $past(mdir_out_i[i])));

    // R7: receiving lane keeps its master output low
    p_in_low_r7: assert property (@(posedge clk) disable iff (rst)
      (warm && !$past(mdir_out_i[i])) |-> (mclk_o[i] == 1'b0));

    // R5: passthrough output tracks the oscillator two cycles late
    p_pass_follow_r5: assert property (@(posedge clk) disable iff (rst)
      (warm && $past(lane_pt_act[i]))
        |-> (mclk_o[i] == ($past(ref_osc_i, 2) ^ $past(inv_m_i[i]))));

    // R2: a main-stage terminal event flips the master output two edges on
    p_mtog_r2: assert property (@(posedge clk) disable iff (rst)
      (warm && lane_mtog[i] && norm) ##1 (norm && $stable(inv_m_i[i]))
        |=> !$stable(mclk_o[i]));

    // R4: in normal mode a fine-stage event only lands with a master event
    p_btog_on_mtog_r4: assert property (@(posedge clk) disable iff (rst)
      (warm && norm && lane_btog[i]) |-> lane_mtog[i]);
  end

endmodule

bind audio_clk_div audio_clk_div_chk #(.NL(NL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_osc_i   (ref_osc_i),
  .mdir_out_i  (mdir_out_i),
  .inv_m_i     (inv_m_i),
  .inv_b_i     (inv_b_i),
  .mclk_o      (mclk_o),
  .mclk_oe_o   (mclk_oe_o),
  .bclk_o      (bclk_o),
  .lane_pt_act (lane_pt_act),
  .lane_mtog   (lane_mtog),
  .lane_btog   (lane_btog)
);

// File: tb/sim_audio_clk_div.sv
module sim_audio_clk_div;

  localparam int CLK_P = 10;
  localparam int NL = 2;
  localparam int MW = 8;
  localparam int FW = 4;
  localparam int HS = 2;   // system reference half period in core cycles
  localparam int HO = 3;   // oscillator half period
  localparam int HI = 5;   // external master clock half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_sys = 1'b0, ref_osc = 1'b0, ext_m = 1'b0;
  logic [NL-1:0]    src = '0, pre8 = '0, pass = '0, dout = '0, invm = '0, invb = '0;
  logic [NL*MW-1:0] mdiv = '0;
  logic [NL*FW-1:0] fdiv = '0;
  logic [NL-1:0]    mclk_o, mclk_oe_o, bclk_o;
  logic [1:0]       osc_h = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_clk_div u0 (
    .clk(clk), .rst(rst), .ref_sys_i(ref_sys), .ref_osc_i(ref_osc),
    .mclk_in_i({NL{ext_m}}), .src_sel_i(src), .pre8_i(pre8), .mdiv_i(mdiv),
    .fdiv_i(fdiv), .pass_i(pass), .mdir_out_i(dout), .inv_m_i(invm),
    .inv_b_i(invb), .mclk_o(mclk_o), .mclk_oe_o(mclk_oe_o), .bclk_o(bclk_o)
  );

  initial forever begin repeat (HS) @(negedge clk); ref_sys = ~ref_sys; end
  initial forever begin repeat (HO) @(negedge clk); ref_osc = ~ref_osc; end
  initial forever begin repeat (HI) @(negedge clk); ext_m = ~ext_m; end

  always @(posedge clk) osc_h <= {osc_h[0], ref_osc};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_lane(input int l, input bit s, input bit p8, input int mf,
                          input int ff, input bit ps, input bit d, input bit im,
                          input bit ib);
    src[l] = s; pre8[l] = p8; pass[l] = ps; dout[l] = d;
    invm[l] = im; invb[l] = ib;
    mdiv[l*MW +: MW] = MW'(mf);
    fdiv[l*FW +: FW] = FW'(ff);
  endtask

  // Expected half periods, in core cycles, from the requirements
  function automatic int m_half(input int l);
    int p, m, h;
    if (pass[l] && src[l]) return HO;
    p = pre8[l] ? 8 : 1;
    m = int'(mdiv[l*MW +: MW]) + 1;
    h = src[l] ? HO : HS;
    return p * m * 2 * h;
  endfunction

  function automatic int b_half(input int l);
    int f;
    f = int'(fdiv[l*FW +: FW]) + 1;
    if (!dout[l]) return f * HI;
    if (pass[l] && src[l]) return f * HO;
    return f * m_half(l);
  endfunction

  function automatic logic smp(input int l, input bit isb);
    return isb ? bclk_o[l] : mclk_o[l];
  endfunction

  // Skip three transitions to let the stages reload, then time one high and one low
  task automatic meas(input int l, input bit isb, output int hi, output int lo);
    logic prv, cur;
    int n;
    n = 0;
    prv = smp(l, isb);
    while (n < 3) begin
      @(negedge clk); cur = smp(l, isb);
      if (cur != prv) n++;
      prv = cur;
    end
    forever begin
      @(negedge clk); cur = smp(l, isb);
      if (cur && !prv) break;
      prv = cur;
    end
    hi = 0;
    do begin @(negedge clk); hi++; end while (smp(l, isb) == 1'b1);
    lo = 0;
    do begin @(negedge clk); lo++; end while (smp(l, isb) == 1'b0);
  endtask

  task automatic lane_check(input int l, input string rm, input string rb);
    int hi, lo;
    if (dout[l]) begin
      meas(l, 1'b0, hi, lo);
      chk(rm, hi, m_half(l));
      chk(rm, lo, m_half(l));
    end
    meas(l, 1'b1, hi, lo);
    chk(rb, hi, b_half(l));
    chk(rb, lo, b_half(l));
  endtask

  initial begin
    int hi, lo;
    int unsigned sd;
    sd = $urandom(32'd4021);

    // R1 / R8: reset state, then polarity on first edge after release
    set_lane(0, 0, 0, 40, 0, 0, 1, 0, 1);
    set_lane(1, 0, 0, 40, 0, 0, 1, 1, 0);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mclk", int'(mclk_o), 0);
    chk("R1 bclk", int'(bclk_o), 0);
    chk("R1 oe", int'(mclk_oe_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 mclk polarity", int'(mclk_o), 2);
    chk("R8 bclk polarity", int'(bclk_o), 1);
    chk("R7 oe driven", int'(mclk_oe_o), 3);

    // R2: largest main divide without prescale, then prescale with M=1
    set_lane(0, 0, 0, 255, 0, 0, 1, 0, 0);
    set_lane(1, 0, 1, 0, 1, 0, 1, 0, 0);
    meas(0, 1'b0, hi, lo);
    chk("R2 M=256 high", hi, 1024);
    chk("R2 M=256 low", lo, 1024);
    lane_check(1, "R2 P=8", "R4 P=8");

    // R6: passthrough ignored with system source
    set_lane(0, 0, 0, 1, 0, 1, 1, 0, 0);
    meas(0, 1'b0, hi, lo);
    chk("R6 pass ignored", hi, 8);

    // R5 / R10: lane 1 passthrough inverted, lane 0 normal divide
    set_lane(1, 1, 1, 7, 2, 1, 1, 1, 0);
    set_lane(0, 1, 0, 2, 1, 0, 1, 0, 1);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R5 follows oscillator", int'(mclk_o[1]), int'(osc_h[1] ^ 1'b1));
    end
    meas(1, 1'b1, hi, lo);
    chk("R5 bclk high", hi, 3 * HO);
    chk("R5 bclk low", lo, 3 * HO);
    lane_check(0, "R10 lane0 mclk", "R10 lane0 bclk");

    // R7: lane 0 receives its master clock
    set_lane(0, 0, 0, 3, 1, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    chk("R7 oe off", int'(mclk_oe_o[0]), 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mclk_o[0] !== 1'b0) chk("R7 mclk low", int'(mclk_o[0]), 0);
    end
    chk("R7 mclk low", int'(mclk_o[0]), 0);
    meas(0, 1'b1, hi, lo);
    chk("R7 bclk from input", hi, 2 * HI);
    chk("R7 bclk from input", lo, 2 * HI);

    // R9: divide change mid-period never produces a partial half
    set_lane(0, 0, 0, 3, 0, 0, 1, 0, 0);
    meas(0, 1'b0, hi, lo);
    repeat (5) @(negedge clk);
    mdiv[0 +: MW] = 8'd9;
    begin
      logic prv, cur;
      int w, seen_new;
      seen_new = 0;
      prv = mclk_o[0];
      do begin @(negedge clk); cur = mclk_o[0]; end while (cur == prv);
      prv = cur;
      for (int k = 0; k < 6; k++) begin
        w = 0;
        do begin @(negedge clk); w++; cur = mclk_o[0]; end while (cur == prv);
        prv = cur;
        if (w == 40) seen_new++;
        chk("R9 whole half", int'(w == 16 || w == 40), 1);
      end
      chk("R9 new value applied", int'(seen_new >= 5), 1);
    end

    // R2 R3 R4 R10: random configurations on both lanes
    for (int it = 0; it < 6; it++) begin
      for (int l = 0; l < NL; l++) begin
        set_lane(l, bit'($urandom % 2), bit'(($urandom % 4) == 0),
                 int'($urandom % 6), int'($urandom % 3),
                 bit'(($urandom % 3) == 0), bit'(($urandom % 5) != 0),
                 bit'($urandom % 2), bit'($urandom % 2));
      end
      for (int l = 0; l < NL; l++) lane_check(l, "R2 R3 mclk", "R4 bclk");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule